// File: doc/BRIEF.md
# Configurable Four-Mode GPIO Port

This block is the control side of one microcontroller I/O port of `NPINS` pins. It sits between the special-function-register write/read bus and the pad cells. It stores the output latch and the per-pin configuration registers. From these it produces registered pad enables for each pin: strong pull-down, strong pull-up, weak pull-up, Schmitt/TTL input select, fast-slew select and high-sink select. Software writes a register address with a data byte. A read at the port address returns the synchronized pad levels, not the latch contents.

Each pin has a two-bit mode: quasi-bidirectional, push-pull, input-only or open-drain. One pin, set by `SPECIAL_PIN`, ignores the mode bits. It is always an input with Schmitt input and no strong drivers. A static strap input decides whether that pin is a plain input with a pull-up under software control, or an external reset input whose port bit always reads 0.

Top module: `gpio_port`

## Requirements
- R1: After reset, mode-1 reads all ones and mode-2 reads all zeros, so every pin is input-only. All strong and weak drivers are off, slew is slow and high-sink is off. Only the special pin reports Schmitt input.
- R2: Mode {mode1,mode2}=01 is push-pull: a latch 1 enables the strong pull-up and a latch 0 enables the strong pull-down. The weak pull-up stays off.
- R3: Mode 11 is open-drain: only the strong pull-down is enabled, and only when the latch is 0.
- R4: Mode 10 is input-only: every driver of the pin is off. External levels are read back unchanged.
- R5: Mode 00 is quasi-bidirectional. A latch 0 drives strong low. A latch 1 leaves only the weak pull-up on, so an external low wins and reads back as 0 even though the latch holds 1.
- R6: In mode 00, a latch change from 0 to 1 turns on the strong pull-up for exactly `BOOST_CYCLES` (default 2) cycles. After that the pin keeps only the weak pull-up.
- R7: A read at address 0 returns the pad levels through a two-flop synchronizer. A pad change becomes visible on the second clock edge after it.
- R8: Register writes take effect at the edge that samples the strobe. Pad control outputs follow one edge later. Address 3 bits select Schmitt input (1) and address 4 bits select fast slew (1), one bit per pin.
- R9: Address 5 high-sink bits exist only on pins in `SINK_MASK` (default 8'h0B). Other bits read 0 and never assert `pad_sink`. Enabling sink never changes the pull-ups.
- R10: The special pin (default pin 2) has no strong pull-up or pull-down in any mode and always reports Schmitt input. With `strap_rst_pin`=0, its weak pull-up follows its mode-2 bit.
- R11: With `strap_rst_pin`=1, the special pin's port-read bit is always 0 and its weak pull-up is on.
- R12: Address map: 0 port latch, 1 mode-1, 2 mode-2, 3 input type, 4 slew, 5 high-sink. Addresses 1 to 5 read back what was stored. Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_rst_pin | input | 1 | Static strap: 1 makes the special pin a reset input |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr` (combinational) |
| pad_in | input | NPINS | Pad input levels |
| pad_pd_en | output | NPINS | Strong pull-down enables |
| pad_pu_strong | output | NPINS | Strong pull-up enables |
| pad_pu_weak | output | NPINS | Weak pull-up enables |
| pad_schmitt | output | NPINS | 1 selects Schmitt input, 0 TTL |
| pad_fast | output | NPINS | 1 selects fast slew |
| pad_sink | output | NPINS | High-sink enables |

## Verification
A write strobe sampled at edge E1 updates the register at E1 and the pad enables at E2. The bench therefore drives at a falling edge and samples pad outputs at the falling edge after E2. The quasi-bidirectional boost is sampled at the falling edges after E2, E3 and E4, where the expected strong pull-up is on, on, then off. Port reads depend on two synchronizer flops, so after any pad change the bench waits two rising edges before it compares `bus_rdata`. Control-register reads are combinational and are checked in the same low phase.

// File: rtl/gpio_pkg.sv
// Shared types and register addresses for the GPIO port.
// Assumes a 3-bit register address space.
package gpio_pkg;
    typedef enum logic [1:0] {
        MODE_QUASI = 2'b00,
        MODE_PUSH  = 2'b01,
        MODE_INPUT = 2'b10,
        MODE_DRAIN = 2'b11
    } pin_mode_e;

    localparam logic [2:0] ADDR_PORT  = 3'd0;
    localparam logic [2:0] ADDR_MODE1 = 3'd1;
    localparam logic [2:0] ADDR_MODE2 = 3'd2;
    localparam logic [2:0] ADDR_ITYPE = 3'd3;
    localparam logic [2:0] ADDR_SLEW  = 3'd4;
    localparam logic [2:0] ADDR_SINK  = 3'd5;
endpackage

// File: rtl/gpio_regs.sv
// Register file of the port: latch, two mode registers, input type,
// slew and high-sink. Assumes one write per cycle, no byte enables.
// Sink bits of pins outside SINK_MASK are held at zero.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int              NPINS     = 8,
    parameter logic [NPINS-1:0] SINK_MASK = 8'h0B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] latch_q,
    output logic [NPINS-1:0] mode1_q,
    output logic [NPINS-1:0] mode2_q,
    output logic [NPINS-1:0] itype_q,
    output logic [NPINS-1:0] slew_q,
    output logic [NPINS-1:0] sink_q
);
    // Store written data in the addressed register; reset to input-only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
            mode1_q <= '1;
            mode2_q <= '0;
            itype_q <= '0;
            slew_q  <= '0;
            sink_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_PORT:  latch_q <= wdata;
                ADDR_MODE1: mode1_q <= wdata;
                ADDR_MODE2: mode2_q <= wdata;
                ADDR_ITYPE: itype_q <= wdata;
                ADDR_SLEW:  slew_q  <= wdata;
                ADDR_SINK:  sink_q  <= wdata & SINK_MASK;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for the pad inputs. Assumes the pads are
// asynchronous to clk; the output lags by STAGES edges.
module gpio_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] d,
    output logic [NPINS-1:0] q
);
    logic [STAGES-1:0][NPINS-1:0] stg;

    // Shift pad levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pin_drive.sv
// Per-pin pad control: decodes the two-bit mode and latch into registered
// driver enables, runs the quasi-bidirectional rising-edge boost, and
// applies the fixed input-only behaviour of the special pin.
// Assumes BOOST_CYCLES >= 1 and a static strap.
module gpio_pin_drive
    import gpio_pkg::*;
#(
    parameter int BOOST_CYCLES = 2,
    parameter bit IS_SPECIAL   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    input  logic latch,
    input  logic m1,
    input  logic m2,
    input  logic itype,
    input  logic slew,
    input  logic sink,
    output logic pd_en,
    output logic pu_strong,
    output logic pu_weak,
    output logic schmitt,
    output logic fast,
    output logic hsink
);
    localparam int CW = $clog2(BOOST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BOOST_CYCLES - 1);

    pin_mode_e      mode;
    logic           latch_d, rise, boosting;
    logic [CW-1:0]  cnt;
    logic           n_pd, n_pus, n_puw, n_sch;

    // Decode mode and latch into the next driver enables.
    always_comb begin
        mode     = pin_mode_e'({m1, m2});
        rise     = latch & ~latch_d;
        boosting = rise | (cnt != '0);
        n_pd     = 1'b0;
        n_pus    = 1'b0;
        n_puw    = 1'b0;
        n_sch    = itype;
        if (IS_SPECIAL) begin
            n_sch = 1'b1;
            n_puw = strap | m2;
        end else begin
            case (mode)
                MODE_QUASI: begin
                    n_pd  = ~latch;
                    n_puw = latch;
                    n_pus = latch & boosting;
                end
                MODE_PUSH: begin
                    n_pd  = ~latch;
                    n_pus = latch;
                end
                MODE_DRAIN: n_pd = ~latch;
                default: ;
            endcase
        end
    end

    // Count the remaining boost cycles after a quasi-mode latch rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            latch_d <= 1'b1;
        end else begin
            latch_d <= latch;
            if (!IS_SPECIAL && mode == MODE_QUASI && latch) begin
                if (rise)            cnt <= LOAD;
                else if (cnt != '0)  cnt <= cnt - 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    // Register every pad control so the enables never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_en     <= 1'b0;
            pu_strong <= 1'b0;
            pu_weak   <= 1'b0;
            schmitt   <= IS_SPECIAL;
            fast      <= 1'b0;
            hsink     <= 1'b0;
        end else begin
            pd_en     <= n_pd;
            pu_strong <= n_pus;
            pu_weak   <= n_puw;
            schmitt   <= n_sch;
            fast      <= slew;
            hsink     <= sink;
        end
    end
endmodule

// File: rtl/gpio_port.sv
// Top of the GPIO port: register file, pad synchronizer, one drive slice
// per pin, and the read multiplexer. Assumes strap_rst_pin is static.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int               NPINS        = 8,
    parameter int               SPECIAL_PIN  = 2,
    parameter logic [NPINS-1:0] SINK_MASK    = 8'h0B,
    parameter int               BOOST_CYCLES = 2,
    parameter int               SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_rst_pin,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_pd_en,
    output logic [NPINS-1:0] pad_pu_strong,
    output logic [NPINS-1:0] pad_pu_weak,
    output logic [NPINS-1:0] pad_schmitt,
    output logic [NPINS-1:0] pad_fast,
    output logic [NPINS-1:0] pad_sink
);
    localparam logic [NPINS-1:0] SP_MASK = {{(NPINS-1){1'b0}}, 1'b1} << SPECIAL_PIN;

    logic [NPINS-1:0] latch_q, mode1_q, mode2_q, itype_q, slew_q, sink_q;
    logic [NPINS-1:0] pins_q;

    gpio_regs #(.NPINS(NPINS), .SINK_MASK(SINK_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .latch_q(latch_q), .mode1_q(mode1_q),
        .mode2_q(mode2_q), .itype_q(itype_q), .slew_q(slew_q), .sink_q(sink_q)
    );

    gpio_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pins_q)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_drive #(
            .BOOST_CYCLES(BOOST_CYCLES),
            .IS_SPECIAL(i == SPECIAL_PIN)
        ) u_drv (
            .clk(clk), .rst_n(rst_n), .strap(strap_rst_pin),
            .latch(latch_q[i]), .m1(mode1_q[i]), .m2(mode2_q[i]),
            .itype(itype_q[i]), .slew(slew_q[i]), .sink(sink_q[i]),
            .pd_en(pad_pd_en[i]), .pu_strong(pad_pu_strong[i]),
            .pu_weak(pad_pu_weak[i]), .schmitt(pad_schmitt[i]),
            .fast(pad_fast[i]), .hsink(pad_sink[i])
        );
    end

    // Select read data; the port address returns pins, never the latch.
    always_comb begin
        case (bus_addr)
            ADDR_PORT:  bus_rdata = pins_q & ~(strap_rst_pin ? SP_MASK : '0);
            ADDR_MODE1: bus_rdata = mode1_q;
            ADDR_MODE2: bus_rdata = mode2_q;
            ADDR_ITYPE: bus_rdata = itype_q;
            ADDR_SLEW:  bus_rdata = slew_q;
            ADDR_SINK:  bus_rdata = sink_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
// Property checker for gpio_port, attached by bind. Observes ports only.
module gpio_port_chk #(
    parameter int               NPINS       = 8,
    parameter int               SPECIAL_PIN = 2,
    parameter logic [NPINS-1:0] SINK_MASK   = 8'h0B
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strap_rst_pin,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic [NPINS-1:0] bus_wdata,
    input logic [NPINS-1:0] bus_rdata,
    input logic [NPINS-1:0] pad_pd_en,
    input logic [NPINS-1:0] pad_pu_strong,
    input logic [NPINS-1:0] pad_pu_weak,
    input logic [NPINS-1:0] pad_schmitt,
    input logic [NPINS-1:0] pad_sink
);
    localparam logic [NPINS-1:0] SP_MASK = {{(NPINS-1){1'b0}}, 1'b1} << SPECIAL_PIN;

    p_no_contention_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pd_en & pad_pu_strong) == '0);

    p_special_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_pd_en[SPECIAL_PIN] && !pad_pu_strong[SPECIAL_PIN]);

    p_special_schmitt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pad_schmitt[SPECIAL_PIN]);

    p_strap_pullup_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(strap_rst_pin) && strap_rst_pin |-> pad_pu_weak[SPECIAL_PIN]);

    p_strap_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        strap_rst_pin && bus_addr == 3'd0 |-> bus_rdata[SPECIAL_PIN] == 1'b0);

    p_sink_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_sink & ~SINK_MASK) == '0);

    p_itype_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 3'd3 |-> ##2
        ((pad_schmitt & ~SP_MASK) == ($past(bus_wdata, 2) & ~SP_MASK)));
endmodule

bind gpio_port gpio_port_chk #(
    .NPINS(NPINS), .SPECIAL_PIN(SPECIAL_PIN), .SINK_MASK(SINK_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .strap_rst_pin(strap_rst_pin), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_pd_en(pad_pd_en), .pad_pu_strong(pad_pu_strong),
    .pad_pu_weak(pad_pu_weak), .pad_schmitt(pad_schmitt), .pad_sink(pad_sink)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
// Directed bench for gpio_port: one task per scenario, each checking itself.
module sim_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata, pad_in, pd, pus, puw, sch, fst, snk;
    logic [7:0] ext_en = 8'h00, ext_val = 8'h00;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    // Resolve the pads: strong drivers, then external, then weak pull-up.
    for (genvar i = 0; i < 8; i++) begin : g_pad
        assign pad_in[i] = pd[i] ? 1'b0 : pus[i] ? 1'b1 :
                           ext_en[i] ? ext_val[i] : puw[i];
    end

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .strap_rst_pin(strap), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_pd_en(pd), .pad_pu_strong(pus),
        .pad_pu_weak(puw), .pad_schmitt(sch), .pad_fast(fst), .pad_sink(snk)
    );

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Write strobe sampled at the next rising edge; returns in its low phase.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.1 d = bus_rdata;
    endtask

    task automatic settle_pads;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 pd", pd, 8'h00);
        check("R1 pu_strong", pus, 8'h00);
        check("R1 pu_weak", puw, 8'h00);
        check("R1 schmitt", sch, 8'h04);
        check("R1 fast", fst, 8'h00);
        check("R1 sink", snk, 8'h00);
        rd(3'd1, v); check("R1 R12 mode1", v, 8'hFF);
        rd(3'd2, v); check("R1 R12 mode2", v, 8'h00);
    endtask

    task automatic t_push;
        logic [7:0] v;
        wr(3'd0, 8'hA5);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'hFF);
        @(negedge clk);
        check("R2 pd", pd, 8'h5A);
        check("R2 pu_strong", pus, 8'hA1);
        check("R2 R10 pu_weak special only", puw, 8'h04);
        settle_pads();
        rd(3'd0, v); check("R7 push-pull pins", v, 8'hA5);
    endtask

    task automatic t_drain;
        logic [7:0] v;
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'h0F);
        @(negedge clk);
        check("R3 pd", pd, 8'hF0);
        check("R3 pu_strong", pus, 8'h00);
        settle_pads();
        rd(3'd0, v); check("R3 R7 floating pins", v, 8'h04);
        ext_en = 8'hFF; ext_val = 8'hFF;
        settle_pads();
        rd(3'd0, v); check("R3 R7 external high", v, 8'h0F);
    endtask

    task automatic t_input;
        logic [7:0] v;
        wr(3'd2, 8'h00);
        @(negedge clk);
        check("R4 pd", pd, 8'h00);
        check("R4 pu_strong", pus, 8'h00);
        check("R4 R10 pu_weak", puw, 8'h00);
        ext_val = 8'h3C;
        settle_pads();
        rd(3'd0, v); check("R4 R7 external pattern", v, 8'h3C);
    endtask

    task automatic t_quasi;
        logic [7:0] v;
        ext_en = 8'h00;
        wr(3'd1, 8'h00);
        @(negedge clk);
        check("R5 latch0 strong low", pd, 8'hF0);
        check("R5 latch1 weak", puw, 8'h0B);
        check("R5 no strong high", pus, 8'h00);
        wr(3'd0, 8'hFF);
        @(negedge clk);
        check("R6 boost cycle 1", pus, 8'hF0);
        check("R6 pd released", pd, 8'h00);
        @(negedge clk);
        check("R6 boost cycle 2", pus, 8'hF0);
        @(negedge clk);
        check("R6 boost ended", pus, 8'h00);
        check("R5 weak after boost", puw, 8'hFB);
        ext_en = 8'hFF; ext_val = 8'h00;
        settle_pads();
        rd(3'd0, v); check("R5 R7 external low wins", v, 8'h00);
        wr(3'd0, 8'h00);
        @(negedge clk);
        check("R5 latch0 all strong low", pd, 8'hFB);
        check("R6 no boost on fall", pus, 8'h00);
    endtask

    task automatic t_types;
        logic [7:0] v;
        wr(3'd3, 8'hF0);
        wr(3'd4, 8'h81);
        check("R8 schmitt one edge after reg", sch, 8'hF4);
        @(negedge clk);
        check("R8 fast", fst, 8'h81);
        rd(3'd3, v); check("R12 itype readback", v, 8'hF0);
        rd(3'd4, v); check("R12 slew readback", v, 8'h81);
    endtask

    task automatic t_sink;
        logic [7:0] v;
        wr(3'd5, 8'hFF);
        @(negedge clk);
        check("R9 sink only capable pins", snk, 8'h0B);
        check("R9 sink leaves strong pull-up", pus, 8'h00);
        check("R9 sink leaves weak pull-up", puw, 8'h00);
        rd(3'd5, v); check("R9 sink readback", v, 8'h0B);
    endtask

    task automatic t_reserved;
        logic [7:0] v;
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'h55);
        @(negedge clk);
        rd(3'd6, v); check("R12 addr6 reads 0", v, 8'h00);
        rd(3'd7, v); check("R12 addr7 reads 0", v, 8'h00);
        rd(3'd1, v); check("R12 mode1 untouched", v, 8'h00);
        check("R12 pd untouched", pd, 8'hFB);
    endtask

    task automatic t_strap;
        logic [7:0] v;
        ext_val = 8'hFF;
        strap = 1'b1;
        settle_pads();
        check("R11 forced pull-up", puw[2] ? 8'h01 : 8'h00, 8'h01);
        rd(3'd0, v); check("R11 special bit reads 0", v, 8'h00);
        strap = 1'b0;
        settle_pads();
        rd(3'd0, v); check("R10 special bit in GPIO use", v, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push();
        t_drain();
        t_input();
        t_quasi();
        t_types();
        t_sink();
        t_reserved();
        t_strap();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule